// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog timer attached to a small register write bus. A slow tick-enable input stands in for a 1 kHz low-power clock. While the watchdog is enabled, its timeout counter advances by one on each tick. Firmware keeps the watchdog quiet by writing a two-word refresh key. If the counter reaches the programmed timeout, the block trips. A wrong refresh word, a late second word, or a refresh that lands too early while window mode is active also trips it. On a trip the block drives a system reset request. When the control register asks for it, an interrupt is raised first.

After reset the configuration registers are open. Writing the control register ends this initial phase. From then on the configuration can only change if the allow-update bit was set. In that case each change needs a timed two-word unlock key first. A wrong or late unlock word trips the watchdog, just like a bad refresh.

The write bus is a valid/ready channel. A write transfers on a clock edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is high in normal operation and drops for good once a trip has started. A master must then hold its write until `wr_ready` returns, which happens only after `rst_n`.

Top module: `wdk_key_timer`

## Requirements
- R1: Reset state. After `rst_n` the outputs are `irq`=0, `sys_rst`=0 and `wr_ready`=1. The control register is cleared, so the watchdog starts disabled. While disabled, ticks never cause a trip.
- R2: Timeout. The timeout is 32 bits: address 1 holds bits 31:16 and address 2 holds bits 15:0. While enabled (control bit 0), the counter starts at zero and counts `tick_en` cycles. The block trips on the clock edge of the tick that brings the count to the timeout value.
- R3: Refresh. Word 0xA602 written to address 6, followed by 0xB480 between 1 and 20 cycles later, restarts the count from zero.
- R4: Bad refresh. Any other word written to address 6 trips the block. So does a 0xA602 that is not followed by a second word within 20 cycles. While the watchdog is disabled, writes to address 6 are ignored.
- R5: Window mode. Address 3 holds window bits 31:16 and address 4 holds bits 15:0. A window value of zero turns window mode off. With a non-zero window, a refresh key that completes while the count is below the window value trips the block.
- R6: Interrupt first. With control bit 2 set, a trip raises `irq` for exactly 128 cycles, then drops it and raises `sys_rst`. With the bit clear, `sys_rst` rises on the trip edge itself.
- R7: Initial phase. After reset, writes to addresses 0 to 4 take effect directly. A write to the control register (address 0) ends this phase.
- R8: Unlock key. If control bit 1 (allow-update) is set after the initial phase, word 0xC520 written to address 5, followed by 0xD928 within 20 cycles, opens an update window. A wrong or late unlock word trips the block.
- R9: Update window. A configuration write in the cycle right after the second unlock word is ignored. Writes are accepted from the next cycle on. The window closes after one accepted write or after 256 cycles, whichever comes first.
- R10: Lock. If allow-update is clear when the initial phase ends, all writes to address 5 are ignored, including wrong words. The configuration stays fixed until `rst_n`.
- R11: Trip hold. Once a trip has started, `wr_ready` stays low and `sys_rst`, once high, stays high until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per low-power tick |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write accepted when high with `wr_valid` |
| wr_addr | input | 3 | Register address (0 control … 6 refresh) |
| wr_data | input | 16 | Write data |
| irq | output | 1 | Interrupt raised ahead of reset |
| sys_rst | output | 1 | System reset request |

## Verification
The hardest situations to reach are the timing edges of the two key sequences. Examples are a second word arriving exactly 20 cycles after the first versus 21, and a configuration write landing in the cycle straight after the unlock key instead of the cycle after that. The bench sweeps the refresh gap cycle by cycle across the boundary, resetting between points. It sweeps the tick count ahead of a windowed refresh across the window value. It places configuration writes at chosen offsets after the unlock key. Each result is observed through the ports: either a trip, or how many ticks a new setting takes to fire.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  typedef enum logic [2:0] {
    A_CTRL = 3'd0,
    A_TOVH = 3'd1,
    A_TOVL = 3'd2,
    A_WINH = 3'd3,
    A_WINL = 3'd4,
    A_UNLK = 3'd5,
    A_RFSH = 3'd6
  } addr_e;

  typedef enum logic [1:0] {
    TS_IDLE,
    TS_IRQ,
    TS_RST
  } trip_e;

  typedef struct packed {
    logic irq_first;
    logic allow_upd;
    logic en;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  localparam logic [15:0] RFSH_K1 = 16'hA602;
  localparam logic [15:0] RFSH_K2 = 16'hB480;
  localparam logic [15:0] UNLK_K1 = 16'hC520;
  localparam logic [15:0] UNLK_K2 = 16'hD928;
endpackage

// File: rtl/wdk_key_seq.sv
module wdk_key_seq #(
  parameter int unsigned KEY_W = 16,
  parameter logic [KEY_W-1:0] FIRST = '0,
  parameter logic [KEY_W-1:0] SECOND = '1,
  parameter int unsigned GAP = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             wr,
  input  logic [KEY_W-1:0] data,
  output logic             good,
  output logic             bad
);
  localparam int unsigned GW = $clog2(GAP + 1);

  logic          armed;
  logic [GW-1:0] gap_q;

  // gap_q holds how many cycles the current cycle lies after the first word
  always_comb begin
    good = 1'b0;
    bad  = 1'b0;
    if (active) begin
      if (wr) begin
        if (armed) begin
          if (data == SECOND) good = 1'b1;
          else                bad  = 1'b1;
        end else if (data != FIRST) begin
          bad = 1'b1;
        end
      end else if (armed && gap_q == GW'(GAP)) begin
        bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gap_q <= '0;
    end else if (!active || good || bad) begin
      armed <= 1'b0;
      gap_q <= '0;
    end else if (wr && !armed) begin
      armed <= 1'b1;
      gap_q <= GW'(1);
    end else if (armed) begin
      gap_q <= gap_q + GW'(1);
    end
  end
endmodule

// File: rtl/wdk_cfg.sv
module wdk_cfg
  import wdk_pkg::*;
#(
  parameter int unsigned HALF = 16,
  parameter int unsigned KEY_GAP = 20,
  parameter int unsigned UPD_CYC = 256,
  parameter logic [2*HALF-1:0] TOV_RST = 32'h0000_0400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  addr_e             addr,
  input  logic [HALF-1:0]   data,
  output ctrl_t             ctrl,
  output logic [2*HALF-1:0] tov,
  output logic [2*HALF-1:0] win,
  output logic              unl_bad
);
  localparam int unsigned CNT_W = 2 * HALF;
  localparam int unsigned AW    = $clog2(UPD_CYC);

  logic          init_open;
  logic          upd_open;
  logic [AW-1:0] upd_age;
  logic          is_cfg;
  logic          cfg_ok;
  logic          unl_active;
  logic          unl_wr;
  logic          unl_good;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  tov_q;
  logic [CNT_W-1:0]  win_q;

  assign is_cfg     = (addr <= A_WINL);
  assign cfg_ok     = wr && is_cfg && (init_open || (upd_open && upd_age != '0));
  assign unl_active = !init_open && ctrl_q.allow_upd;
  assign unl_wr     = wr && (addr == A_UNLK);

  wdk_key_seq #(
    .KEY_W (HALF),
    .FIRST (UNLK_K1),
    .SECOND(UNLK_K2),
    .GAP   (KEY_GAP)
  ) u_unlock (
    .clk   (clk),
    .rst_n (rst_n),
    .active(unl_active),
    .wr    (unl_wr),
    .data  (data),
    .good  (unl_good),
    .bad   (unl_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_open <= 1'b1;
    end else if (cfg_ok && addr == A_CTRL) begin
      init_open <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_open <= 1'b0;
      upd_age  <= '0;
    end else if (unl_good) begin
      upd_open <= 1'b1;
      upd_age  <= '0;
    end else if (upd_open) begin
      if (cfg_ok || upd_age == AW'(UPD_CYC - 1)) begin
        upd_open <= 1'b0;
        upd_age  <= '0;
      end else begin
        upd_age <= upd_age + AW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tov_q  <= TOV_RST;
      win_q  <= '0;
    end else if (cfg_ok) begin
      case (addr)
        A_CTRL: ctrl_q <= ctrl_t'(data[CTRL_W-1:0]);
        A_TOVH: tov_q[CNT_W-1:HALF] <= data;
        A_TOVL: tov_q[HALF-1:0]     <= data;
        A_WINH: win_q[CNT_W-1:HALF] <= data;
        A_WINL: win_q[HALF-1:0]     <= data;
        default: ;
      endcase
    end
  end

  assign ctrl = ctrl_q;
  assign tov  = tov_q;
  assign win  = win_q;
endmodule

// File: rtl/wdk_count.sv
module wdk_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             halt,
  input  logic             tick,
  input  logic             rfr_good,
  input  logic [CNT_W-1:0] tov,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt,
  output logic             expire,
  output logic             win_bad
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign expire  = en && !halt && tick && (cnt_inc >= {1'b0, tov});
  assign win_bad = rfr_good && (win != '0) && (cnt_q < win);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en || halt || rfr_good) begin
      cnt_q <= '0;
    end else if (tick && cnt_q != '1) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdk_trip.sv
module wdk_trip
  import wdk_pkg::*;
#(
  parameter int unsigned IRQ_HOLD = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic irq_first,
  output logic irq,
  output logic sys_rst,
  output logic busy
);
  localparam int unsigned HW = $clog2(IRQ_HOLD);

  trip_e         st_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TS_IDLE;
      hold_q <= '0;
    end else begin
      case (st_q)
        TS_IDLE: if (req) begin
          st_q   <= irq_first ? TS_IRQ : TS_RST;
          hold_q <= '0;
        end
        TS_IRQ: begin
          if (hold_q == HW'(IRQ_HOLD - 1)) st_q <= TS_RST;
          else                             hold_q <= hold_q + HW'(1);
        end
        default: st_q <= TS_RST;
      endcase
    end
  end

  assign irq     = (st_q == TS_IRQ);
  assign sys_rst = (st_q == TS_RST);
  assign busy    = (st_q != TS_IDLE);
endmodule

// File: rtl/wdk_key_timer.sv
module wdk_key_timer
  import wdk_pkg::*;
#(
  parameter int unsigned HALF = 16,
  parameter int unsigned KEY_GAP = 20,
  parameter int unsigned UPD_CYC = 256,
  parameter int unsigned IRQ_HOLD = 128,
  parameter logic [2*HALF-1:0] TOV_RST = 32'h0000_0400
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_valid,
  output logic            wr_ready,
  input  logic [2:0]      wr_addr,
  input  logic [HALF-1:0] wr_data,
  output logic            irq,
  output logic            sys_rst
);
  localparam int unsigned CNT_W = 2 * HALF;

  addr_e            addr;
  logic             wr_acc;
  logic             busy;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] tov;
  logic [CNT_W-1:0] win;
  logic [CNT_W-1:0] cnt_q;
  logic             cnt_en;
  logic             unl_bad;
  logic             rfr_active;
  logic             rfr_wr;
  logic             rfr_good;
  logic             rfr_bad;
  logic             expire;
  logic             win_bad;
  logic             trip_req;

  assign addr       = addr_e'(wr_addr);
  assign wr_ready   = !busy;
  assign wr_acc     = wr_valid && wr_ready;
  assign cnt_en     = ctrl.en;
  assign rfr_active = ctrl.en && !busy;
  assign rfr_wr     = wr_acc && (addr == A_RFSH);

  wdk_cfg #(
    .HALF   (HALF),
    .KEY_GAP(KEY_GAP),
    .UPD_CYC(UPD_CYC),
    .TOV_RST(TOV_RST)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (wr_acc),
    .addr   (addr),
    .data   (wr_data),
    .ctrl   (ctrl),
    .tov    (tov),
    .win    (win),
    .unl_bad(unl_bad)
  );

  wdk_key_seq #(
    .KEY_W (HALF),
    .FIRST (RFSH_K1),
    .SECOND(RFSH_K2),
    .GAP   (KEY_GAP)
  ) u_refresh (
    .clk   (clk),
    .rst_n (rst_n),
    .active(rfr_active),
    .wr    (rfr_wr),
    .data  (wr_data),
    .good  (rfr_good),
    .bad   (rfr_bad)
  );

  wdk_count #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cnt_en),
    .halt    (busy),
    .tick    (tick_en),
    .rfr_good(rfr_good),
    .tov     (tov),
    .win     (win),
    .cnt     (cnt_q),
    .expire  (expire),
    .win_bad (win_bad)
  );

  assign trip_req = expire || rfr_bad || win_bad || unl_bad;

  wdk_trip #(
    .IRQ_HOLD(IRQ_HOLD)
  ) u_trip (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (trip_req),
    .irq_first(ctrl.irq_first),
    .irq      (irq),
    .sys_rst  (sys_rst),
    .busy     (busy)
  );
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker #(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned IRQ_HOLD = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             sys_rst,
  input logic             wr_ready,
  input logic             cnt_en,
  input logic             rfr_good,
  input logic             win_bad,
  input logic [CNT_W-1:0] cnt_q
);
  localparam int unsigned LW = $clog2(IRQ_HOLD + 1) + 1;

  logic [LW-1:0] irq_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_len <= '0;
    else if (irq) irq_len <= irq_len + LW'(1);
    else          irq_len <= '0;
  end

  assert_irq_rst_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq && sys_rst));

  assert_irq_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (sys_rst && irq_len == LW'(IRQ_HOLD)));

  assert_rst_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> sys_rst);

  assert_ready_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq || sys_rst) |-> !wr_ready);

  assert_window_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_bad && wr_ready) |=> (irq || sys_rst));

  assert_refresh_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rfr_good && cnt_en) |=> (cnt_q == '0));

  assert_idle_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> (cnt_q == '0));
endmodule

bind wdk_key_timer wdk_checker #(
  .CNT_W   (CNT_W),
  .IRQ_HOLD(IRQ_HOLD)
) i_wdk_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq     (irq),
  .sys_rst (sys_rst),
  .wr_ready(wr_ready),
  .cnt_en  (cnt_en),
  .rfr_good(rfr_good),
  .win_bad (win_bad),
  .cnt_q   (cnt_q)
);

// File: tb/test_wdk_key_timer.sv
module test_wdk_key_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        irq;
  logic        sys_rst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  wdk_key_timer i_wdk_key_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_valid(wr_valid),
    .wr_ready(wr_ready),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .sys_rst (sys_rst)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0;
    wr_valid = 1'b0;
    tick_en = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_valid = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic tick();
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    idle(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic setup(input logic [31:0] tov, input logic [31:0] win, input logic [2:0] ctrl);
    wr(3'd1, tov[31:16]);
    wr(3'd2, tov[15:0]);
    wr(3'd3, win[31:16]);
    wr(3'd4, win[15:0]);
    wr(3'd0, {13'd0, ctrl});
  endtask

  task automatic unlock();
    wr(3'd5, 16'hC520);
    wr(3'd5, 16'hD928);
  endtask

  task automatic refresh();
    wr(3'd6, 16'hA602);
    wr(3'd6, 16'hB480);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    reset_dut();
    check("R1 irq", irq, 0);
    check("R1 sys_rst", sys_rst, 0);
    check("R1 wr_ready", wr_ready, 1);
    ticks(1100);
    check("R1 disabled after reset", sys_rst, 0);

    // R2 timeout sweep
    for (int t = 1; t <= 6; t++) begin
      reset_dut();
      setup(t, 0, 3'b001);
      for (int n = 1; n <= t + 1; n++) begin
        tick();
        check($sformatf("R2 tov=%0d tick=%0d", t, n), sys_rst, (n >= t) ? 1 : 0);
      end
    end

    // R2 high half of timeout
    reset_dut();
    setup(32'h0001_0002, 0, 3'b001);
    ticks(4);
    check("R2 high half", sys_rst, 0);

    // R1 disabled ignores ticks, R4 refresh ignored when disabled
    reset_dut();
    setup(3, 0, 3'b000);
    ticks(10);
    check("R1 disabled no trip", sys_rst, 0);
    wr(3'd6, 16'h1234);
    idle(3);
    check("R4 refresh ignored when disabled", sys_rst, 0);

    // R3/R4 refresh gap sweep
    for (int k = 1; k <= 23; k++) begin
      reset_dut();
      setup(1000, 0, 3'b001);
      wr(3'd6, 16'hA602);
      idle(k - 1);
      wr(3'd6, 16'hB480);
      idle(3);
      check($sformatf("R4 gap=%0d", k), sys_rst, (k > 20) ? 1 : 0);
    end

    // R3 refresh reloads the count
    reset_dut();
    setup(4, 0, 3'b001);
    ticks(3);
    refresh();
    ticks(3);
    check("R3 reload no trip", sys_rst, 0);
    tick();
    check("R3 trip after full period", sys_rst, 1);

    // R4 wrong words
    reset_dut();
    setup(1000, 0, 3'b001);
    wr(3'd6, 16'h1234);
    idle(1);
    check("R4 wrong first word", sys_rst, 1);
    reset_dut();
    setup(1000, 0, 3'b001);
    wr(3'd6, 16'hA602);
    wr(3'd6, 16'hA602);
    idle(1);
    check("R4 wrong second word", sys_rst, 1);

    // R6 interrupt before reset
    reset_dut();
    setup(2, 0, 3'b101);
    ticks(2);
    check("R6 irq raised", irq, 1);
    check("R6 reset held back", sys_rst, 0);
    idle(126);
    check("R6 irq at 127", irq, 1);
    check("R6 no reset at 127", sys_rst, 0);
    check("R11 ready low", wr_ready, 0);
    idle(1);
    check("R6 irq dropped at 128", irq, 0);
    check("R6 reset at 128", sys_rst, 1);
    idle(50);
    check("R11 reset sticky", sys_rst, 1);
    check("R11 ready stays low", wr_ready, 0);

    // R5 window sweep
    for (int n = 0; n <= 7; n++) begin
      reset_dut();
      setup(1000, 5, 3'b001);
      ticks(n);
      refresh();
      idle(2);
      check($sformatf("R5 ticks=%0d", n), sys_rst, (n < 5) ? 1 : 0);
    end

    // R7 initial phase closes with the control write
    reset_dut();
    setup(3, 0, 3'b000);
    wr(3'd0, 16'h0001);
    ticks(5);
    check("R7 control closed after first write", sys_rst, 0);

    // R8/R9 update window timing
    reset_dut();
    setup(3, 0, 3'b010);
    unlock();
    wr(3'd0, 16'h0003);
    idle(300);
    ticks(5);
    check("R9 write right after key ignored", sys_rst, 0);
    unlock();
    idle(1);
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'h0003);
    ticks(5);
    check("R9 window closes after one write", sys_rst, 0);
    unlock();
    idle(300);
    wr(3'd0, 16'h0003);
    ticks(5);
    check("R9 window closes after 256 cycles", sys_rst, 0);
    unlock();
    idle(1);
    wr(3'd0, 16'h0003);
    ticks(1);
    check("R8 update applied, new tov 2 not reached", sys_rst, 0);
    tick();
    check("R8 update applied, trip at tov 2", sys_rst, 1);

    // R8 wrong and late unlock words
    reset_dut();
    setup(1000, 0, 3'b010);
    wr(3'd5, 16'h1111);
    idle(1);
    check("R8 wrong unlock trips", sys_rst, 1);
    reset_dut();
    setup(1000, 0, 3'b010);
    wr(3'd5, 16'hC520);
    idle(20);
    wr(3'd5, 16'hD928);
    idle(2);
    check("R8 late unlock trips", sys_rst, 1);

    // R10 lock without allow-update
    reset_dut();
    setup(3, 0, 3'b000);
    wr(3'd5, 16'h1111);
    idle(2);
    check("R10 wrong unlock ignored", sys_rst, 0);
    unlock();
    idle(1);
    wr(3'd0, 16'h0001);
    ticks(5);
    check("R10 config stays fixed", sys_rst, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule